// File: doc/BRIEF.md
# Operand Bypass Select Unit

This block decides, for a five-stage in-order integer pipeline, where each operand of the instruction now in the execute stage should come from. The choices are the register file, the result held in the execute/memory pipeline register, or the value held in the memory/writeback pipeline register. A third decision covers the store-data input of a store that has reached the memory stage. That input can take the value in the memory/writeback register, so a load followed at once by a store of the loaded register runs without a bubble.

The unit is purely combinational. It compares source register numbers against the destination numbers and write enables of the two older instructions and drives the mux select codes. The muxes, the register file and the load-use stall logic sit outside it.

Parameters set the register-number width and the number of execute-stage source operands. A generate option decides whether register number zero is a hard-wired constant that must never be bypassed.

Top module: `fwd_unit`

## Requirements
- R1: When no qualified older destination matches an execute-stage source, that operand's select is 2'b00, which means the register file.
- R2: When the execute/memory destination matches a source, and that stage writes a register to a nonzero destination, the operand's select is 2'b10.
- R3: When only the memory/writeback stage qualifies (it writes, its destination is nonzero, and that destination equals the source), the operand's select is 2'b01.
- R4: When both older stages qualify for the same source, the execute/memory stage wins and the select is 2'b10.
- R5: A destination of register 0 never produces a bypass, on any of the three paths.
- R6: A stage whose register-write enable is low never produces a bypass. A lower-priority stage that does qualify is still selected.
- R7: The store-data select is 1 when the memory/writeback stage writes a nonzero destination equal to the memory-stage store's rt field. Otherwise it is 0.
- R8: Each execute-stage operand is resolved independently of the others. Operand index 0 occupies bits [1:0] of the select output and operand index 1 occupies bits [3:2].
- R9: The code 2'b11 is never driven on an operand select.
- R10: The selects are a function of the present inputs only. They settle within the same cycle as the inputs change, with no register stage.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_i | input | NUM_SRC*REG_AW | Source register numbers of the execute-stage instruction, operand 0 in the low slice |
| exmem_rd_i | input | REG_AW | Destination register of the instruction in the execute/memory register |
| exmem_we_i | input | 1 | Register-write enable of that instruction |
| memwb_rd_i | input | REG_AW | Destination register of the instruction in the memory/writeback register |
| memwb_we_i | input | 1 | Register-write enable of that instruction |
| mem_rt_i | input | REG_AW | Store-data register field of the memory-stage instruction |
| alu_sel_o | output | NUM_SRC*2 | Per-operand select: 00 register file, 10 execute/memory, 01 memory/writeback |
| st_sel_o | output | 1 | Store-data select: 1 takes the memory/writeback value |

## Verification
The embedded checks assume that the inputs change as one coherent set, so that a select is never judged against a half-updated mix of register fields. The bench keeps to this by assigning every input in a single statement, away from the clock edge. The checks also assume that the external stall logic never lets a consumer sit right behind a load. The bench's vectors treat an execute/memory match as a finished ALU result, and they rely on no load-use case.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   typedef enum logic [1:0] {
      SEL_REGFILE = 2'b00,
      SEL_MEMWB   = 2'b01,
      SEL_EXMEM   = 2'b10
   } alu_sel_e;

   localparam int unsigned SEL_W = 2;

endpackage

// File: rtl/fwd_hit.sv
module fwd_hit #(
   parameter int unsigned REG_AW     = 5,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [REG_AW-1:0] src_i,
   input  logic [REG_AW-1:0] dst_i,
   input  logic              we_i,
   output logic              hit_o
);

   logic same;
   assign same = (src_i == dst_i);

   generate
      if (ZERO_GUARD) begin : g_zero_guard
         logic dst_nonzero;
         assign dst_nonzero = |dst_i;
         assign hit_o       = we_i & dst_nonzero & same;
      end else begin : g_no_guard
         assign hit_o = we_i & same;
      end
   endgenerate

   always_comb begin
      if (hit_o) begin
         AST_HIT_NEEDS_WE: assert (we_i) else $error("hit without write enable"); // R6
      end
   end

endmodule

// File: rtl/fwd_alu_pick.sv
module fwd_alu_pick
   import fwd_pkg::*;
#(
   parameter int unsigned REG_AW     = 5,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [REG_AW-1:0] src_i,
   input  logic [REG_AW-1:0] exmem_rd_i,
   input  logic              exmem_we_i,
   input  logic [REG_AW-1:0] memwb_rd_i,
   input  logic              memwb_we_i,
   output logic [SEL_W-1:0]  sel_o
);

   logic exmem_hit;
   logic memwb_hit;
   alu_sel_e pick;

   fwd_hit #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_hit_exmem (
      .src_i (src_i),
      .dst_i (exmem_rd_i),
      .we_i  (exmem_we_i),
      .hit_o (exmem_hit)
   );

   fwd_hit #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_hit_memwb (
      .src_i (src_i),
      .dst_i (memwb_rd_i),
      .we_i  (memwb_we_i),
      .hit_o (memwb_hit)
   );

   // younger producer first
   always_comb begin
      if (exmem_hit)      pick = SEL_EXMEM;
      else if (memwb_hit) pick = SEL_MEMWB;
      else                pick = SEL_REGFILE;
   end

   assign sel_o = pick;

   always_comb begin
      AST_SEL_LEGAL: assert (sel_o != 2'b11) else $error("illegal select"); // R9
      if (sel_o == 2'b10) begin
         AST_EXMEM_QUAL: assert (exmem_we_i && (exmem_rd_i == src_i) && (!ZERO_GUARD || exmem_rd_i != '0))
            else $error("exmem bypass unqualified"); // R2
      end
      if (sel_o == 2'b01) begin
         AST_MEMWB_QUAL: assert (memwb_we_i && (memwb_rd_i == src_i) && (!ZERO_GUARD || memwb_rd_i != '0))
            else $error("memwb bypass unqualified"); // R3
         AST_YOUNG_WINS: assert (!(exmem_we_i && (exmem_rd_i == src_i) && (!ZERO_GUARD || exmem_rd_i != '0)))
            else $error("older value chosen over younger"); // R4
      end
      if (ZERO_GUARD && src_i == '0) begin
         AST_ZERO_NEVER: assert (sel_o == 2'b00) else $error("register zero bypassed"); // R5
      end
   end

endmodule

// File: rtl/fwd_store_pick.sv
module fwd_store_pick #(
   parameter int unsigned REG_AW     = 5,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [REG_AW-1:0] rt_i,
   input  logic [REG_AW-1:0] memwb_rd_i,
   input  logic              memwb_we_i,
   output logic              sel_o
);

   fwd_hit #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_hit_st (
      .src_i (rt_i),
      .dst_i (memwb_rd_i),
      .we_i  (memwb_we_i),
      .hit_o (sel_o)
   );

   always_comb begin
      if (sel_o) begin
         AST_STORE_QUAL: assert (memwb_we_i && (memwb_rd_i == rt_i) && (!ZERO_GUARD || rt_i != '0))
            else $error("store bypass unqualified"); // R7
      end
   end

endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
   import fwd_pkg::*;
#(
   parameter int unsigned REG_AW     = 5,
   parameter int unsigned NUM_SRC    = 2,
   parameter bit          ZERO_GUARD = 1'b1
) (
   input  logic [NUM_SRC-1:0][REG_AW-1:0] ex_src_i,
   input  logic [REG_AW-1:0]              exmem_rd_i,
   input  logic                           exmem_we_i,
   input  logic [REG_AW-1:0]              memwb_rd_i,
   input  logic                           memwb_we_i,
   input  logic [REG_AW-1:0]              mem_rt_i,
   output logic [NUM_SRC-1:0][SEL_W-1:0]  alu_sel_o,
   output logic                           st_sel_o
);

   localparam int unsigned SEL_BITS = NUM_SRC * SEL_W;

   generate
      if (REG_AW < 1 || REG_AW > 8) begin : g_bad_aw
         $error("REG_AW must lie in 1..8");
      end
      if (NUM_SRC < 1 || NUM_SRC > 4) begin : g_bad_src
         $error("NUM_SRC must lie in 1..4");
      end
      if (SEL_BITS != NUM_SRC * 2) begin : g_bad_sel
         $error("select width mismatch");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SRC; gi++) begin : g_op
         fwd_alu_pick #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_pick (
            .src_i      (ex_src_i[gi]),
            .exmem_rd_i (exmem_rd_i),
            .exmem_we_i (exmem_we_i),
            .memwb_rd_i (memwb_rd_i),
            .memwb_we_i (memwb_we_i),
            .sel_o      (alu_sel_o[gi])
         );
      end
   endgenerate

   fwd_store_pick #(.REG_AW(REG_AW), .ZERO_GUARD(ZERO_GUARD)) u_store (
      .rt_i       (mem_rt_i),
      .memwb_rd_i (memwb_rd_i),
      .memwb_we_i (memwb_we_i),
      .sel_o      (st_sel_o)
   );

endmodule

// File: tb/fwd_unit_tb.sv
module fwd_unit_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #5 clk = ~clk;

   logic [1:0][4:0] ex_src;
   logic [4:0] exmem_rd, memwb_rd, mem_rt;
   logic exmem_we, memwb_we;
   logic [1:0][1:0] alu_sel;
   logic st_sel;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   fwd_unit dut_i (
      .ex_src_i   (ex_src),
      .exmem_rd_i (exmem_rd),
      .exmem_we_i (exmem_we),
      .memwb_rd_i (memwb_rd),
      .memwb_we_i (memwb_we),
      .mem_rt_i   (mem_rt),
      .alu_sel_o  (alu_sel),
      .st_sel_o   (st_sel)
   );

   // drive all inputs in one statement at negedge, sample 2 ns later (same cycle: R10)
   task automatic apply(input logic [4:0] s0, input logic [4:0] s1,
                        input logic [4:0] xrd, input logic xwe,
                        input logic [4:0] wrd, input logic wwe, input logic [4:0] rt,
                        input logic [1:0] e0, input logic [1:0] e1, input logic est,
                        input string req);
      @(negedge clk);
      {ex_src, exmem_rd, exmem_we, memwb_rd, memwb_we, mem_rt} = {s1, s0, xrd, xwe, wrd, wwe, rt};
      #2;
      n_vec++;
      if (alu_sel[0] !== e0 || alu_sel[1] !== e1 || st_sel !== est) begin
         n_bad++;
         $display("FAIL %s: got op0=%b op1=%b st=%b expected op0=%b op1=%b st=%b",
                  req, alu_sel[0], alu_sel[1], st_sel, e0, e1, est);
      end
   endtask

   task automatic t_reset_state();   // R1
      apply(0, 0, 0, 0, 0, 0, 0, 2'b00, 2'b00, 1'b0, "R1 reset state");
   endtask

   task automatic t_no_match();      // R1
      apply(3, 4, 7, 1, 9, 1, 8, 2'b00, 2'b00, 1'b0, "R1 no match");
   endtask

   task automatic t_ex_to_ex();      // R2 R8 R10
      apply(5, 2, 5, 1, 6, 1, 1, 2'b10, 2'b00, 1'b0, "R2 op0 from exmem");
      apply(2, 5, 5, 1, 6, 1, 1, 2'b00, 2'b10, 1'b0, "R8 op1 from exmem");
   endtask

   task automatic t_mem_to_ex();     // R3
      apply(6, 6, 5, 1, 6, 1, 0, 2'b01, 2'b01, 1'b0, "R3 both from memwb");
   endtask

   task automatic t_priority();      // R4
      apply(5, 5, 5, 1, 5, 1, 2, 2'b10, 2'b10, 1'b0, "R4 younger wins");
   endtask

   task automatic t_zero_reg();      // R5
      apply(0, 0, 0, 1, 0, 1, 0, 2'b00, 2'b00, 1'b0, "R5 register zero");
   endtask

   task automatic t_we_low();        // R6
      apply(5, 3, 5, 0, 5, 1, 0, 2'b01, 2'b00, 1'b0, "R6 exmem we low falls to memwb");
      apply(5, 5, 5, 0, 5, 0, 5, 2'b00, 2'b00, 1'b0, "R6 both we low");
   endtask

   task automatic t_store();         // R7
      apply(1, 2, 9, 1, 3, 1, 3, 2'b00, 2'b00, 1'b1, "R7 load then store");
      apply(1, 2, 9, 1, 3, 0, 3, 2'b00, 2'b00, 1'b0, "R7 store with we low");
      apply(1, 2, 9, 1, 3, 1, 4, 2'b00, 2'b00, 1'b0, "R7 store rt mismatch");
   endtask

   task automatic t_mixed();         // R8
      apply(5, 6, 5, 1, 6, 1, 6, 2'b10, 2'b01, 1'b1, "R8 mixed sources");
   endtask

   task automatic t_sweep_legal();   // R9: no code 11 when both stages target the operand
      for (int a = 0; a < 4; a++) begin
         for (int b = 0; b < 4; b++) begin
            apply(5'(a), 5'(b), 5'(a), 1, 5'(b), 1, 0,
                  (a != 0) ? 2'b10 : 2'b00,
                  (b != 0) ? ((a == b) ? 2'b10 : 2'b01) : 2'b00,
                  1'b0, "R9 sweep");
            if (alu_sel[0] == 2'b11 || alu_sel[1] == 2'b11) begin
               n_bad++;
               $display("FAIL R9: got %b/%b expected no 11", alu_sel[0], alu_sel[1]);
            end
         end
      end
   endtask

   initial begin
      {ex_src, exmem_rd, exmem_we, memwb_rd, memwb_we, mem_rt} = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      t_reset_state();
      t_no_match();
      t_ex_to_ex();
      t_mem_to_ex();
      t_priority();
      t_zero_reg();
      t_we_low();
      t_store();
      t_mixed();
      t_sweep_legal();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

endmodule